// File: doc/BRIEF.md
# Palette Index Pixel Formatter

This block sits between a frame-buffer fetch stream and a display data bus. It accepts 32-bit words through a valid/ready handshake. Each word carries packed palette indices of 1, 2, 4 or 8 bits, or two raw 16-bit pixels. The block hands out one pixel per output handshake. A palette index selects one of 256 colour entries. Each entry holds 12 bits, four per component, and a separate write port fills the entries. The chosen colour is then placed on a 16-bit output bus. It goes there either right-aligned or widened to 5-6-5 by copying the top bits of each component.

Sub-word indices can be taken starting from the least significant end of the word or from the most significant end. The configuration inputs are sampled together with each accepted word, so a word is always unpacked under one consistent setting. A new word is taken only after the last pixel of the current word has left the block.

Top module: `pal_pix_fmt`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: An accepted word gives out_valid in the next cycle. It produces exactly 32, 16, 8, 4 or 2 output items when cfg_fmt is 0, 1, 2, 3 or 4 (1-, 2-, 4-, 8-bit indices, raw 16-bit pixels).
- R3: With cfg_msb_first=0 and b bits per index, item k uses the index in word bits [k*b+b-1 : k*b].
- R4: With cfg_msb_first=1 and b bits per index, item k uses the index in word bits [31-k*b : 32-(k+1)*b].
- R5: An index selects the palette entry at that address. Entries are 12 bits with R in [11:8], G in [7:4] and B in [3:0]. A write (pal_we, pal_waddr, pal_wdata) is visible from the next cycle.
- R6: With cfg_wide565=0, out_data is {4'b0000, R, G, B}.
- R7: With cfg_wide565=1, out_data is {R[3:0], R[3], G[3:0], G[3:2], B[3:0], B[3]}.
- R8: In raw mode (cfg_fmt bit 2 set), the palette is bypassed. The pixel in bits [15:0] comes out before the pixel in bits [31:16], whatever the value of cfg_msb_first.
- R9: In raw mode, cfg_raw565=0 takes the colour as pixel bits [11:0]. cfg_raw565=1 takes R=p[15:12], G=p[10:7] and B=p[4:1].
- R10: in_ready stays 0 while any item of the current word is unaccepted, and it is 1 in the cycle after the last item is accepted. During a stall, out_valid and out_data hold.
- R11: The configuration inputs are captured when a word is accepted. Changing them while that word is unpacked has no effect on its items.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 3 | Pixel format: 0..3 index width 1/2/4/8 bits, bit 2 set = raw 16-bit |
| cfg_msb_first | input | 1 | Take indices from the top of the word down |
| cfg_wide565 | input | 1 | Output 5-6-5 widened colour instead of right-aligned 12 bits |
| cfg_raw565 | input | 1 | Raw pixels are 5-6-5 (else 12 bits in [11:0]) |
| pal_we | input | 1 | Palette write strobe |
| pal_waddr | input | 8 | Palette write address |
| pal_wdata | input | 12 | Palette write colour |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Frame-buffer word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the pixel |
| out_data | output | 16 | Formatted pixel |

## Verification
The first item of a word appears one cycle after the input handshake. Each later item appears in the cycle after the previous output handshake, because the palette read and the formatting are combinational from the held word and position. in_ready rises one cycle after the last item is accepted. The bench drives inputs just after a rising edge. Its monitor samples at the falling edge, so every sample shows the values that the next rising edge commits. The stall and re-open checks are taken at fixed falling edges counted from the handshake.

// File: rtl/pal_fmt_pkg.sv
package pal_fmt_pkg;
  localparam int WORD_W  = 32;
  localparam int COLOR_W = 12;
  localparam int OUT_W   = 16;
  localparam int IDX_W   = 8;
  localparam int CNT_W   = $clog2(WORD_W);
  localparam int HALF_W  = WORD_W / 2;

  typedef struct packed {
    logic [2:0] fmt;
    logic       msb_first;
    logic       wide565;
    logic       raw565;
  } cfg_t;

  function automatic logic fmt_is_raw(logic [2:0] fmt);
    return fmt[2];
  endfunction

  // position of the last item in a word for a given format
  function automatic logic [CNT_W-1:0] last_pos(logic [2:0] fmt);
    logic [CNT_W-1:0] r;
    if (fmt[2]) r = CNT_W'(1);
    else        r = CNT_W'((WORD_W - 1) >> fmt[1:0]);
    return r;
  endfunction

  // index extraction for either parse direction
  function automatic logic [IDX_W-1:0] pick_index(logic [WORD_W-1:0] w, logic [1:0] lg,
                                                  logic msb, logic [CNT_W-1:0] k);
    int b;
    int sh;
    logic [WORD_W-1:0] t;
    logic [WORD_W-1:0] m;
    b  = 1 << lg;
    if (msb) sh = WORD_W - (int'(k) + 1) * b;
    else     sh = int'(k) * b;
    t = w >> sh;
    m = (WORD_W'(1) << b) - WORD_W'(1);
    t = t & m;
    return t[IDX_W-1:0];
  endfunction

  function automatic logic [COLOR_W-1:0] raw_color(logic [HALF_W-1:0] p, logic sel565);
    logic [COLOR_W-1:0] c;
    if (sel565) c = {p[15:12], p[10:7], p[4:1]};
    else        c = p[11:0];
    return c;
  endfunction

  function automatic logic [OUT_W-1:0] map_out(logic [COLOR_W-1:0] c, logic wide);
    logic [OUT_W-1:0] o;
    if (wide) o = {c[11:8], c[11], c[7:4], c[7:6], c[3:0], c[3]};
    else      o = {{(OUT_W-COLOR_W){1'b0}}, c};
    return o;
  endfunction
endpackage

// File: rtl/pal_store.sv
module pal_store
  import pal_fmt_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int CW     = COLOR_W,
  localparam int AW    = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] rdata
);
  logic [CW-1:0] entry [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                          entry[i] <= '0;
      else if (we && (waddr == AW'(i)))   entry[i] <= wdata;
    end
  end

  assign rdata = entry[raddr];
endmodule

// File: rtl/word_seq.sv
module word_seq
  import pal_fmt_pkg::*;
#(
  parameter int WW = WORD_W,
  localparam int CW = $clog2(WW)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [WW-1:0] in_word,
  input  cfg_t          cfg_in,
  output logic          in_ready,
  input  logic          item_ready,
  output logic          item_valid,
  output logic [CW-1:0] item_pos,
  output logic          item_last,
  output logic [WW-1:0] word_q,
  output cfg_t          cfg_q,
  output logic          word_start,
  output logic          word_done
);
  logic          busy;
  logic [CW-1:0] pos;

  assign in_ready   = !busy;
  assign item_valid = busy;
  assign item_pos   = pos;
  assign item_last  = (pos == last_pos(cfg_q.fmt));
  assign word_start = in_valid && in_ready;
  assign word_done  = busy && item_ready && item_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      pos    <= '0;
      word_q <= '0;
      cfg_q  <= '0;
    end else if (word_start) begin
      busy   <= 1'b1;
      pos    <= '0;
      word_q <= in_word;
      cfg_q  <= cfg_in;
    end else if (busy && item_ready) begin
      if (item_last) busy <= 1'b0;
      else           pos  <= pos + CW'(1);
    end
  end
endmodule

// File: rtl/pix_decode.sv
module pix_decode
  import pal_fmt_pkg::*;
#(
  parameter int WW = WORD_W,
  parameter int IW = IDX_W,
  localparam int CW = $clog2(WW),
  localparam int HW = WW / 2
)(
  input  logic [WW-1:0]      word_q,
  input  cfg_t               cfg_q,
  input  logic [CW-1:0]      pos,
  output logic               is_raw,
  output logic [IW-1:0]      idx,
  output logic [COLOR_W-1:0] raw_col
);
  logic [HW-1:0] half;

  assign is_raw = fmt_is_raw(cfg_q.fmt);
  assign half   = pos[0] ? word_q[WW-1:HW] : word_q[HW-1:0];
  assign idx    = is_raw ? '0 : pick_index(word_q, cfg_q.fmt[1:0], cfg_q.msb_first, pos);
  assign raw_col = raw_color(half, cfg_q.raw565);
endmodule

// File: rtl/pal_pix_fmt.sv
module pal_pix_fmt
  import pal_fmt_pkg::*;
#(
  parameter int PAL_DEPTH = 256,
  localparam int PAL_AW   = $clog2(PAL_DEPTH),
  localparam int POS_W    = CNT_W
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cfg_fmt,
  input  logic                cfg_msb_first,
  input  logic                cfg_wide565,
  input  logic                cfg_raw565,
  input  logic                pal_we,
  input  logic [PAL_AW-1:0]   pal_waddr,
  input  logic [COLOR_W-1:0]  pal_wdata,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WORD_W-1:0]   in_word,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [OUT_W-1:0]    out_data
);
  cfg_t               cfg_in;
  cfg_t               cfg_q;
  logic [WORD_W-1:0]  word_q;
  logic [POS_W-1:0]   pos;
  logic               item_last;
  logic               is_raw;
  logic [IDX_W-1:0]   idx;
  logic [COLOR_W-1:0] raw_col;
  logic [COLOR_W-1:0] pal_col;
  logic [COLOR_W-1:0] sel_col;

  // events brought out for the checker
  logic word_start;
  logic word_done;
  logic wide_q;

  assign cfg_in = '{fmt: cfg_fmt, msb_first: cfg_msb_first,
                    wide565: cfg_wide565, raw565: cfg_raw565};

  word_seq #(.WW(WORD_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .cfg_in     (cfg_in),
    .in_ready   (in_ready),
    .item_ready (out_ready),
    .item_valid (out_valid),
    .item_pos   (pos),
    .item_last  (item_last),
    .word_q     (word_q),
    .cfg_q      (cfg_q),
    .word_start (word_start),
    .word_done  (word_done)
  );

  pix_decode #(.WW(WORD_W), .IW(IDX_W)) u_dec (
    .word_q  (word_q),
    .cfg_q   (cfg_q),
    .pos     (pos),
    .is_raw  (is_raw),
    .idx     (idx),
    .raw_col (raw_col)
  );

  pal_store #(.DEPTH(PAL_DEPTH), .CW(COLOR_W)) u_pal (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (pal_we),
    .waddr (pal_waddr),
    .wdata (pal_wdata),
    .raddr (idx[PAL_AW-1:0]),
    .rdata (pal_col)
  );

  assign wide_q   = cfg_q.wide565;
  assign sel_col  = is_raw ? raw_col : pal_col;
  assign out_data = map_out(sel_col, wide_q);
endmodule

// File: rtl/pal_pix_fmt_chk.sv
module pal_pix_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data,
  input logic        pal_we,
  input logic        wide_q,
  input logic        word_start,
  input logic        word_done
);
  AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R10
  AST_DONE_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> in_ready); // R10
  AST_START_PRESENTS: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |=> out_valid); // R2
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !pal_we) |=> (out_valid && $stable(out_data))); // R10
  AST_WIDE_REPL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && wide_q) |-> (out_data[11] == out_data[15] &&
                               out_data[6:5] == out_data[10:9] &&
                               out_data[0] == out_data[4])); // R7
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_q) |-> (out_data[15:12] == 4'h0)); // R6
endmodule

bind pal_pix_fmt pal_pix_fmt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .pal_we     (pal_we),
  .wide_q     (wide_q),
  .word_start (word_start),
  .word_done  (word_done)
);

// File: tb/tb_pal_pix_fmt.sv
module tb_pal_pix_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_fmt = '0;
  logic        cfg_msb_first = 1'b0;
  logic        cfg_wide565 = 1'b0;
  logic        cfg_raw565 = 1'b0;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_waddr = '0;
  logic [11:0] pal_wdata = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready;
  logic [15:0] out_data;

  typedef struct { logic [15:0] d; string tag; } exp_t;
  exp_t        expq[$];
  logic [11:0] pal_m [256];
  int total = 0;
  int bad = 0;
  int fires = 0;
  int cyc = 0;
  int rdy_mode = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  pal_pix_fmt dut (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_msb_first(cfg_msb_first),
    .cfg_wide565(cfg_wide565), .cfg_raw565(cfg_raw565), .pal_we(pal_we),
    .pal_waddr(pal_waddr), .pal_wdata(pal_wdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      check(1'b0, "watchdog", 32'(cyc), 32'd100000);
      summary();
    end
  end

  // downstream ready pattern
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = (cyc % 3) != 1;
      default: out_ready = 1'b0;
    endcase
  end

  // monitor: sample mid-cycle what the next edge commits
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      fires++;
      if (expq.size() == 0) check(1'b0, "R2 extra item", 32'(out_data), 32'hx);
      else begin
        exp_t e;
        e = expq.pop_front();
        check(out_data === e.d, e.tag, 32'(out_data), 32'(e.d));
      end
    end
  end

  function automatic logic [15:0] fmt_out(logic [11:0] c, logic wd);
    if (wd) return {c[11:8], c[11], c[7:4], c[7], c[6], c[3:0], c[3]};
    return {4'h0, c};
  endfunction

  task automatic send_word(input logic [31:0] w, input logic [2:0] f, input logic d,
                           input logic wd, input logic r5, input string tag);
    int n;
    int b;
    n = f[2] ? 2 : (32 >> f[1:0]);
    b = 1 << f[1:0];
    for (int k = 0; k < n; k++) begin
      exp_t e;
      logic [11:0] c;
      if (f[2]) begin
        logic [15:0] p;
        p = (k == 0) ? w[15:0] : w[31:16];
        c = r5 ? {p[15:12], p[10:7], p[4:1]} : p[11:0];
      end else begin
        int lo;
        logic [7:0] ix;
        lo = d ? (31 - k*b - (b-1)) : k*b;
        ix = '0;
        for (int j = 0; j < b; j++) ix[j] = w[lo + j];
        c = pal_m[ix];
      end
      e.d = fmt_out(c, wd);
      if (tag != "") e.tag = tag;
      else if (f[2]) e.tag = r5 ? "R9" : "R8,R9";
      else if (wd) e.tag = "R7";
      else if (d) e.tag = "R4,R6";
      else e.tag = "R3,R6";
      expq.push_back(e);
    end
    @(posedge clk); #1;
    in_word = w; cfg_fmt = f; cfg_msb_first = d; cfg_wide565 = wd; cfg_raw565 = r5;
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    // scramble configuration while the word is unpacked (R11)
    in_word = ~w; cfg_fmt = ~f; cfg_msb_first = ~d; cfg_wide565 = ~wd; cfg_raw565 = ~r5;
  endtask

  task automatic drain();
    @(negedge clk);
    while (expq.size() != 0 || out_valid) @(negedge clk);
  endtask

  task automatic pal_write(input logic [7:0] a, input logic [11:0] v);
    drain();
    @(posedge clk); #1;
    pal_we = 1'b1; pal_waddr = a; pal_wdata = v; pal_m[a] = v;
    @(posedge clk); #1;
    pal_we = 1'b0;
  endtask

  initial begin
    logic [15:0] held;
    int base;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);

    for (int i = 0; i < 256; i++) pal_write(8'(i), 12'((i * 173 + 41) & 12'hfff));

    // item counts per format (R2)
    for (int f = 0; f < 5; f++) begin
      drain();
      base = fires;
      send_word(32'h9e37_79b9, 3'(f), 1'b0, 1'b0, 1'b0, "");
      drain();
      check(fires - base == (f == 4 ? 2 : (32 >> f)), "R2 item count",
            32'(fires - base), 32'(f == 4 ? 2 : (32 >> f)));
    end

    // main sweep of index formats, directions and mappings
    for (int f = 0; f < 4; f++)
      for (int d = 0; d < 2; d++)
        for (int wd = 0; wd < 2; wd++) begin
          rdy_mode = wd;
          send_word(32'hc3a5_0f96 ^ (32'(f) * 32'h1111_0101), 3'(f), 1'(d), 1'(wd), 1'b0, "");
          send_word(32'h0123_4567 + 32'(d * 77), 3'(f), 1'(d), 1'(wd), 1'b1, "");
        end
    drain();
    rdy_mode = 0;

    // raw pixels: direction must not matter
    for (int r5 = 0; r5 < 2; r5++)
      for (int d = 0; d < 2; d++)
        for (int wd = 0; wd < 2; wd++)
          send_word(32'hf0e1_7b2c ^ 32'(r5 * 32'h0808_1010), 3'd4, 1'(d), 1'(wd), 1'(r5), "");

    // configuration captured at acceptance
    send_word(32'h6d2b_79f8, 3'd1, 1'b1, 1'b1, 1'b0, "R11");
    send_word(32'h8000_0001, 3'd0, 1'b1, 1'b0, 1'b0, "R11");

    // palette update visible to the next word
    pal_write(8'h5a, 12'h9c3);
    send_word(32'h5a5a_5a5a, 3'd3, 1'b0, 1'b1, 1'b0, "R5");
    pal_write(8'h01, 12'h0f0);
    send_word(32'h0000_0001, 3'd0, 1'b0, 1'b0, 1'b0, "R5");

    // stall holds output and blocks input
    drain();
    rdy_mode = 2;
    send_word(32'h1122_3344, 3'd3, 1'b0, 1'b0, 1'b0, "R10");
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R10 in_ready during word", 32'(in_ready), 32'd0);
    check(out_valid == 1'b1, "R10 out_valid in stall", 32'(out_valid), 32'd1);
    check(out_data == expq[0].d, "R10 first item in stall", 32'(out_data), 32'(expq[0].d));
    held = out_data;
    @(negedge clk);
    check(out_data == held, "R10 held data", 32'(out_data), 32'(held));
    rdy_mode = 0;
    drain();
    check(in_ready == 1'b1, "R10 reopened", 32'(in_ready), 32'd1);

    drain();
    check(expq.size() == 0, "R2 all items seen", 32'(expq.size()), 32'd0);
    done = 1;
    summary();
  end
endmodule